// File: doc/BRIEF.md
# Transport Stream Null-Packet Rate Adapter

This block drains a dual-clock FIFO that is filled by a capture stage running on the tuner's clock. The tuner clock has no fixed relation to the local clock and may run anywhere from a few hundred hertz up to about 11 MHz. The adapter runs on the fixed local byte clock and must hand a serializer exactly one transport stream byte on every cycle. When enough tuner data is buffered, it forwards whole 188-byte packets. When too little is buffered, it sends null packets, so the output byte rate never changes.

Each FIFO word is 10 bits wide. Bit 9 is the payload flag: 1 means payload and 0 means parity. Bit 8 is the sync flag. Bits 7:0 carry the byte. A word is a sync word when bits 9 and 8 are both 1. The FIFO is of the show-ahead kind: while it is not empty, the head word is present on `fifo_rd_data`, and asserting `fifo_rd_en` for one cycle removes that word at the next clock edge.

The controller has two states. `ST_NULL` means the packet on the output is a generated null packet. `ST_FWD` means it is a packet being forwarded from the FIFO. The state changes only at a packet boundary: the first cycle after reset, or after the 188th byte of a packet. The "launch" transition enters `ST_FWD`, from either state, when the head word is a sync word and the FIFO level is at least 188 words. The "stuff" transition enters `ST_NULL` when that condition does not hold. Between real packets the controller also does "hunting": while a null packet is being sent, it pops and discards every head word that is not a sync word.

Top module: `ts_rate_adapter`

## Requirements
- R1: While `rst_n` is low, `ts_valid`, `ts_start` and `fifo_rd_en` are all 0.
- R2: From the first clock edge after reset is released, `ts_valid` is 1 on every cycle.
- R3: `ts_start` is 1 on the first byte after reset and then on every 188th cycle, marking byte 0 of each packet. It is 0 on all other cycles.
- R4: A null packet is output as 0x47, 0x1F, 0xFF, 0x10, followed by 184 bytes of 0xFF.
- R5: At a packet boundary a real packet is launched exactly when all three hold: the FIFO is not empty, the head word has bit 9 = 1 and bit 8 = 1, and `fifo_level` is at least 188. Otherwise a null packet starts. This choice is never revisited inside a packet.
- R6: A launched packet consumes one FIFO word per cycle for 188 cycles, in FIFO order. The byte (bits 7:0) of each word with bit 9 = 1 appears on `ts_data` one cycle after the word is read.
- R7: A word with bit 9 = 0 (parity) read inside a forwarded packet is consumed, and its output slot carries 0xFF.
- R8: While a null packet is being sent, each head word that is not a sync word is popped and discarded, one per cycle. A sync word at the head is left in place.
- R9: `fifo_rd_en` is never 1 while `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_rd_data | input | 10 | Head word of the FIFO: payload flag, sync flag, byte |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_level | input | LVL_W | Number of words held in the FIFO |
| fifo_rd_en | output | 1 | Pop the head word at the next edge |
| ts_data | output | 8 | Output stream byte |
| ts_valid | output | 1 | Output byte is valid |
| ts_start | output | 1 | Output byte is byte 0 of a packet |

## Verification
A behavioural model in the bench is compared with the design on every cycle, under several input patterns.

- An empty FIFO after reset exposes the null packet content and the packet spacing.
- Leading junk and parity words ahead of a packet show whether hunting discards exactly the non-sync words.
- A back-to-back burst with a stray parity word inside one packet tells apart correct 0xFF stuffing and the discarding of the leftover word from loss of alignment.
- A slow trickle, plus a packet held at 187 words before its last word arrives, shows that a launch waits for the full threshold and happens only at a boundary.

// File: rtl/ts_rate_pkg.sv
package ts_rate_pkg;

    localparam logic [7:0] TS_SYNC_BYTE  = 8'h47;
    localparam logic [7:0] TS_STUFF_BYTE = 8'hFF;
    localparam logic [7:0] NULL_HDR_B1   = 8'h1F;
    localparam logic [7:0] NULL_HDR_B3   = 8'h10;

    // FIFO word layout, MSB first
    typedef struct packed {
        logic       payload;  // 1 = payload byte, 0 = parity byte
        logic       sync;     // 1 = packet sync byte
        logic [7:0] data;
    } ts_word_t;

    typedef enum logic {
        ST_NULL = 1'b0,
        ST_FWD  = 1'b1
    } pkt_mode_e;

endpackage

// File: rtl/ts_word_decode.sv
module ts_word_decode
    import ts_rate_pkg::*;
(
    input  logic [9:0] raw,
    input  logic       empty,
    output logic       present,
    output logic       sync_word,
    output logic       payload,
    output logic [7:0] data
);

    ts_word_t w;

    assign w         = ts_word_t'(raw);
    assign present   = !empty;
    assign sync_word = present & w.payload & w.sync;
    assign payload   = present & w.payload;
    assign data      = w.data;

endmodule

// File: rtl/ts_slot_counter.sv
module ts_slot_counter #(
    parameter int PKT_LEN = 188,
    parameter int IDX_W   = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] idx_next,
    output logic             boundary
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    logic primed_q;

    assign boundary = !primed_q || (idx_q == LAST_IDX);
    assign idx_next = boundary ? '0 : idx_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            idx_q    <= idx_next;
            primed_q <= 1'b1;
        end
    end

    // R3: the slot index never leaves the packet
    a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);

endmodule

// File: rtl/ts_null_pattern.sv
module ts_null_pattern
    import ts_rate_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       null_byte
);

    always_comb begin
        case (idx)
            IDX_W'(0): null_byte = TS_SYNC_BYTE;
            IDX_W'(1): null_byte = NULL_HDR_B1;
            IDX_W'(3): null_byte = NULL_HDR_B3;
            default:   null_byte = TS_STUFF_BYTE;
        endcase
    end

endmodule

// File: rtl/ts_rate_adapter.sv
module ts_rate_adapter
    import ts_rate_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int LVL_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [9:0]       fifo_rd_data,
    input  logic             fifo_empty,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             fifo_rd_en,
    output logic [7:0]       ts_data,
    output logic             ts_valid,
    output logic             ts_start
);

    localparam int               IDX_W     = $clog2(PKT_LEN);
    localparam logic [LVL_W-1:0] LAUNCH_LV = LVL_W'(PKT_LEN);

    logic             head_present;
    logic             head_sync;
    logic             head_payload;
    logic [7:0]       head_data;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_next;
    logic             boundary;
    logic [7:0]       null_byte;
    logic             launch;
    logic             rd_want;
    logic [7:0]       byte_d;
    pkt_mode_e        mode_q;
    pkt_mode_e        mode_d;

    ts_word_decode u_decode (
        .raw       (fifo_rd_data),
        .empty     (fifo_empty),
        .present   (head_present),
        .sync_word (head_sync),
        .payload   (head_payload),
        .data      (head_data)
    );

    ts_slot_counter #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_q    (idx_q),
        .idx_next (idx_next),
        .boundary (boundary)
    );

    ts_null_pattern #(.IDX_W(IDX_W)) u_null (
        .idx       (idx_next),
        .null_byte (null_byte)
    );

    assign launch = boundary && head_sync && (fifo_level >= LAUNCH_LV);

    // next-state logic: decided only at packet boundaries
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_NULL: if (launch)              mode_d = ST_FWD;
            ST_FWD:  if (boundary && !launch) mode_d = ST_NULL;
        endcase
    end

    // output selection for the byte presented after the next edge
    always_comb begin
        rd_want = 1'b0;
        byte_d  = null_byte;
        unique case (mode_d)
            ST_FWD: begin
                rd_want = 1'b1;
                byte_d  = head_payload ? head_data : TS_STUFF_BYTE;
            end
            ST_NULL: begin
                rd_want = !head_sync;
                byte_d  = null_byte;
            end
        endcase
    end

    assign fifo_rd_en = rst_n && head_present && rd_want;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_NULL;
        else        mode_q <= mode_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_valid <= 1'b0;
            ts_start <= 1'b0;
            ts_data  <= '0;
        end else begin
            ts_valid <= 1'b1;
            ts_start <= boundary;
            ts_data  <= byte_d;
        end
    end

    // spacing tracker used by the packet-gap assertion
    logic [IDX_W:0] gap_q;
    logic           seen_start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q        <= '0;
            seen_start_q <= 1'b0;
        end else if (ts_start) begin
            gap_q        <= '0;
            seen_start_q <= 1'b1;
        end else begin
            gap_q        <= gap_q + 1'b1;
        end
    end

    // R9: never pop an empty FIFO
    a_r9_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    // R2: once valid, the stream stays valid
    a_r2_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |=> ts_valid);

    // R3: consecutive packet starts are exactly one packet apart
    a_r3_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_start && seen_start_q) |-> (gap_q == (IDX_W+1)'(PKT_LEN - 1)));

    // R5: a forwarded packet only begins when the level reached the threshold
    a_r5_launch_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_start && mode_q == ST_FWD) |-> ($past(fifo_level) >= LAUNCH_LV));

endmodule

// File: tb/ts_rate_adapter_tb.sv
module ts_rate_adapter_tb;

    localparam int PKT   = 188;
    localparam int LVL_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [9:0]       rd_data = '0;
    logic             empty = 1'b1;
    logic [LVL_W-1:0] level = '0;
    logic             rd_en;
    logic [7:0]       ts_data;
    logic             ts_valid;
    logic             ts_start;

    always #4 clk = ~clk;

    ts_rate_adapter #(.PKT_LEN(PKT), .LVL_W(LVL_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_rd_data (rd_data),
        .fifo_empty   (empty),
        .fifo_level   (level),
        .fifo_rd_en   (rd_en),
        .ts_data      (ts_data),
        .ts_valid     (ts_valid),
        .ts_start     (ts_start)
    );

    logic [9:0] fq[$];
    logic [9:0] src[$];
    int  n_chk = 0;
    int  n_fail = 0;
    int  push_gap = 1;
    int  push_cnt = 0;
    bit  hold_rst = 1'b1;
    bit  done = 1'b0;

    bit         m_primed = 1'b0;
    int         m_idx = 0;
    bit         m_fwd = 1'b0;
    bit         have_exp = 1'b0;
    bit         last_rd = 1'b0;
    logic [7:0] e_byte = '0;
    bit         e_start = 1'b0;
    string      e_tag = "R4";

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] null_byte(int i);
        if (i == 0) return 8'h47;
        if (i == 1) return 8'h1F;
        if (i == 3) return 8'h10;
        return 8'hFF;
    endfunction

    function automatic logic [9:0] pkt_word(int seed, int i);
        if (i == 0) return {2'b11, 8'h47};
        return {2'b10, 8'(seed * 7 + i * 13)};
    endfunction

    task automatic add_pkt(int seed, int lo, int hi);
        for (int i = lo; i < hi; i++) src.push_back(pkt_word(seed, i));
    endtask

    task automatic add_parity(int n);
        for (int i = 0; i < n; i++) src.push_back({2'b00, 8'(8'hA0 + i)});
    endtask

    task automatic add_junk(int n);
        for (int i = 0; i < n; i++) src.push_back({2'b10, 8'(8'h30 + i)});
        src.push_back({2'b01, 8'h47});  // sync flag on a parity word: not a sync word
    endtask

    task automatic step();
        bit         bnd;
        bit         present;
        bit         hs;
        bit         erd;
        logic [9:0] h;
        string      rtag;
        @(negedge clk);
        if (have_exp) begin
            chk("R2", "ts_valid", 32'(ts_valid), 32'd1);
            chk("R3", "ts_start", 32'(ts_start), 32'(e_start));
            chk(e_tag, "ts_data", 32'(ts_data), 32'(e_byte));
        end else if (!rst_n) begin
            chk("R1", "ts_valid in reset", 32'(ts_valid), 32'd0);
            chk("R1", "ts_start in reset", 32'(ts_start), 32'd0);
        end
        if (last_rd) void'(fq.pop_front());
        last_rd = 1'b0;
        if (src.size() > 0) begin
            push_cnt++;
            if (push_cnt >= push_gap) begin
                push_cnt = 0;
                fq.push_back(src.pop_front());
            end
        end
        rst_n   = !hold_rst;
        empty   = (fq.size() == 0);
        level   = LVL_W'(fq.size());
        rd_data = empty ? 10'h000 : fq[0];
        #1;
        chk("R9", "rd_en while empty", 32'(rd_en & empty), 32'd0);
        if (!rst_n) begin
            chk("R1", "rd_en in reset", 32'(rd_en), 32'd0);
            have_exp = 1'b0;
            m_primed = 1'b0;
        end else begin
            bnd     = !m_primed || (m_idx == PKT - 1);
            present = (fq.size() > 0);
            h       = present ? fq[0] : 10'h000;
            hs      = present && h[9] && h[8];
            m_primed = 1'b1;
            if (bnd) begin
                m_idx = 0;
                m_fwd = hs && (fq.size() >= PKT);
                rtag  = "R5";
            end else begin
                m_idx++;
                rtag = m_fwd ? "R6" : "R8";
            end
            e_start = bnd;
            if (m_fwd) begin
                erd = present;
                if (present && h[9]) begin
                    e_byte = h[7:0];
                    e_tag  = "R6";
                end else begin
                    e_byte = 8'hFF;
                    e_tag  = "R7";
                end
            end else begin
                erd    = present && !hs;
                e_byte = null_byte(m_idx);
                e_tag  = "R4";
            end
            chk(rtag, "fifo_rd_en", 32'(rd_en), 32'(erd));
            have_exp = 1'b1;
            last_rd  = erd;
        end
    endtask

    task automatic run(int n);
        repeat (n) step();
    endtask

    initial begin
        // R1, R2, R3, R4: reset, then null packets from an empty FIFO
        hold_rst = 1'b1;
        run(4);
        hold_rst = 1'b0;
        run(400);

        // R8, R5, R6: junk and parity ahead of a packet are hunted away
        add_junk(4);
        add_parity(3);
        add_pkt(1, 0, PKT);
        run(700);

        // R6, R7, R8: back-to-back burst with a parity word inside packet 3
        add_pkt(2, 0, PKT);
        add_parity(16);
        add_pkt(3, 0, 60);
        add_parity(1);
        add_pkt(3, 60, PKT);
        add_parity(16);
        add_pkt(4, 0, PKT);
        run(1600);

        // R5: slow trickle, launch waits for the full threshold
        push_gap = 3;
        add_pkt(5, 0, PKT);
        add_pkt(6, 0, PKT);
        run(1800);
        push_gap = 1;

        // R1: reset in the middle of the stream, then drain
        hold_rst = 1'b1;
        run(3);
        hold_rst = 1'b0;
        run(400);

        // R5, R8: 187 words with a sync head must not launch; the 188th does
        add_pkt(7, 0, PKT - 1);
        run(600);
        add_pkt(7, PKT - 1, PKT);
        run(600);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule